// File: doc/BRIEF.md
# Multi-Mode Pixel Port Assembler

This block sits between a pixel stream and a color-lookup and conversion back end. Pixel data arrives on a 16-bit input, with one word per pixel clock. In the narrow-bus modes only the low byte of that word carries data. An 8-bit command register holds a 4-bit color mode, which sets three things: how many input words make one pixel, how the bits of those words are unpacked, and whether each pixel leaves as a palette index or as an 8:8:8 RGB triple that bypasses the palette. The rates run from two pixels per clock up to three clocks per pixel. One packed mode gives two pixels for every three words.

The same register holds a power-down bit and a test bit. Power-down forces the output to the blank level and keeps the register contents. The test bit turns on a 16-bit rotate-and-XOR signature over every emitted pixel. The test bit and the power-down bit together raise a flag that tells the clock generator to stop. While the blank input is high, the word counter restarts, so the first word after blanking always opens a new pixel.

Top module: `pix_port_assembler`

## Requirements
- R1: After reset the command register reads 0x00. A write stores every bit except bits 3 and 2, which always read back as 0.
- R2: The mode is {cmd[4], cmd[7], cmd[6], cmd[5]}, and 0 is the reset value. Mode 0 emits one palette index per word, taken from pix_in[7:0]. Each pixel appears with pix_valid = 01 and pix_direct = 0, and the index sits in pix0[7:0] with the upper bits zero.
- R3: Modes 1, 4, 5 and 6 take two bytes, low byte first, and form a 15-bit value with red in [14:10], green in [9:5] and blue in [4:0]. Each 5-bit channel widens to 8 bits as {c, c[4:2]}. pix0 = {R, G, B} with pix_direct = 1.
- R4: Mode 3 takes two bytes, low byte first, and forms a 5:6:5 value with red in [15:11], green in [10:5] and blue in [4:0]. The 6-bit green widens as {c, c[5:4]}.
- R5: Modes 2 and 7 take three bytes in the order blue, green, red. The pixel is emitted on the third byte.
- R6: Mode 8 emits two palette indices per word: pix_in[7:0] on pix0 and pix_in[15:8] on pix1, with pix_valid = 11.
- R7: Mode 9 (5:5:5 in pix_in[14:0]) and mode 10 (5:6:5) emit one direct pixel per 16-bit word.
- R8: Mode 11 takes two words. The first word carries green in [15:8] and blue in [7:0]. The low byte of the second word carries red.
- R9: Mode 12 takes three words that form a 48-bit little-endian string. On the third word, pix0 = bits [23:0] and pix1 = bits [47:24], both direct, with pix_valid = 11.
- R10: A pixel appears on the outputs one clock after the edge that samples its final word. When blank_in is sampled high, or on a command write, the cycle produces no pixel and a partly collected pixel is dropped. blank_out follows blank_in with the same one-clock delay.
- R11: Modes 13 to 15 emit no pixels, hold blank_out high and pix0/pix1 at zero, and leave the checksum unchanged.
- R12: When cmd[0] is set, pdown_out is high, no pixel is emitted, blank_out is high, and the register keeps its value.
- R13: synth_off is high exactly when cmd[1] and cmd[0] are both set. While cmd[1] is set, each emitted pixel p (lane 0 first) updates the checksum as s = rotl1(s) XOR (p[15:0] XOR {8'h00, p[23:16]}).
- R14: A write that changes cmd[1] from 0 to 1 clears the checksum. While cmd[1] is 0, the checksum holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command write data |
| cmd_rdata | output | 8 | Command register read-back |
| blank_in | input | 1 | Blanking interval marker |
| pix_in | input | 16 | Input word; low byte only in narrow modes |
| pix_valid | output | 2 | Lane valid flags: bit 0 for pix0, bit 1 for pix1 |
| pix_direct | output | 1 | 1 = RGB bypass pixel, 0 = palette index |
| pix0 | output | 24 | First pixel lane {R,G,B} or index in [7:0] |
| pix1 | output | 24 | Second pixel lane |
| blank_out | output | 1 | Blank level request toward the converters |
| pdown_out | output | 1 | Power-down request toward palette and DACs |
| synth_off | output | 1 | Clock synthesizer stop request |
| checksum | output | 16 | Running output signature |

## Verification
The block is built with its package defaults: a 16-bit input word, 24-bit pixels, two output lanes and a 16-bit signature. At these sizes the full mode space is small enough for the bench to program all sixteen modes in turn, reserved ones included. In each mode it streams twelve words, a count that splits evenly into groups of one, two and three, and it recomputes every pixel and the running signature with its own shift-and-add channel expansion. Separate directed runs cover blanking in the middle of a pixel, power-down with the register kept, the reserved bits, and arming and freezing the signature.

// File: rtl/pxa_pkg.sv
package pxa_pkg;
  localparam int CMD_W  = 8;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;
  localparam int RGB_W  = 24;
  localparam int SUM_W  = 16;
  localparam int LANES  = 2;
  localparam int MAXW   = 3;
  localparam int ASM_W  = MAXW * BUS_W;
  localparam int CNT_W  = $clog2(MAXW + 1);

  typedef enum logic [2:0] {
    FMT_IDX1, FMT_IDX2, FMT_555, FMT_565, FMT_888, FMT_PACK, FMT_RSV
  } fmt_e;

  typedef struct packed {
    fmt_e             fmt;
    logic             wide;
    logic [CNT_W-1:0] words;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c.fmt = FMT_RSV; c.wide = 1'b1; c.words = '0;
    case (m)
      4'd0:                   begin c.fmt = FMT_IDX1; c.wide = 1'b0; c.words = 2'd1; end
      4'd1, 4'd4, 4'd5, 4'd6: begin c.fmt = FMT_555;  c.wide = 1'b0; c.words = 2'd2; end
      4'd3:                   begin c.fmt = FMT_565;  c.wide = 1'b0; c.words = 2'd2; end
      4'd2, 4'd7:             begin c.fmt = FMT_888;  c.wide = 1'b0; c.words = 2'd3; end
      4'd8:                   begin c.fmt = FMT_IDX2; c.wide = 1'b1; c.words = 2'd1; end
      4'd9:                   begin c.fmt = FMT_555;  c.wide = 1'b1; c.words = 2'd1; end
      4'd10:                  begin c.fmt = FMT_565;  c.wide = 1'b1; c.words = 2'd1; end
      4'd11:                  begin c.fmt = FMT_888;  c.wide = 1'b1; c.words = 2'd2; end
      4'd12:                  begin c.fmt = FMT_PACK; c.wide = 1'b1; c.words = 2'd3; end
      default:                begin c.fmt = FMT_RSV;  c.wide = 1'b1; c.words = 2'd0; end
    endcase
    return c;
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic logic [RGB_W-1:0] from555(input logic [14:0] v);
    return {widen5(v[14:10]), widen5(v[9:5]), widen5(v[4:0])};
  endfunction

  function automatic logic [RGB_W-1:0] from565(input logic [15:0] v);
    return {widen5(v[15:11]), widen6(v[10:5]), widen5(v[4:0])};
  endfunction

  function automatic logic [SUM_W-1:0] fold24(input logic [RGB_W-1:0] p);
    return p[15:0] ^ {8'h00, p[23:16]};
  endfunction

  function automatic logic [SUM_W-1:0] sum_step(input logic [SUM_W-1:0] s,
                                                 input logic [RGB_W-1:0] p);
    return {s[SUM_W-2:0], s[SUM_W-1]} ^ fold24(p);
  endfunction
endpackage

// File: rtl/pxa_cmd_reg.sv
module pxa_cmd_reg
  import pxa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] rdata,
  output mode_cfg_t        cfg,
  output logic             pdown,
  output logic             test_on,
  output logic             synth_off,
  output logic             test_arm
);
  localparam logic [CMD_W-1:0] KEEP_MASK = 8'hF3;

  logic [CMD_W-1:0] cmd_q;
  logic [3:0]       mode;

  always_ff @(posedge clk) begin
    if (!rst_n)  cmd_q <= '0;
    else if (we) cmd_q <= wdata & KEEP_MASK;
  end

  always_comb begin
    rdata     = cmd_q;
    mode      = {cmd_q[4], cmd_q[7:5]};
    cfg       = decode_mode(mode);
    pdown     = cmd_q[0];
    test_on   = cmd_q[1];
    synth_off = cmd_q[1] & cmd_q[0];
    test_arm  = we & wdata[1] & ~cmd_q[1];
  end
endmodule

// File: rtl/pxa_gather.sv
module pxa_gather
  import pxa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] words,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] w0,
  output logic [BUS_W-1:0] w1,
  output logic             last
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx = words - CNT_W'(1);
    last     = !restart && (cnt == last_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      w0  <= '0;
      w1  <= '0;
    end else if (restart || last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == '0) w0 <= din;
      else           w1 <= din;
    end
  end
endmodule

// File: rtl/pxa_format.sv
module pxa_format
  import pxa_pkg::*;
(
  input  mode_cfg_t        cfg,
  input  logic [BUS_W-1:0] w0,
  input  logic [BUS_W-1:0] w1,
  input  logic [BUS_W-1:0] din,
  output logic [RGB_W-1:0] lane0,
  output logic [RGB_W-1:0] lane1,
  output logic [LANES-1:0] mask,
  output logic             direct
);
  logic [ASM_W-1:0] asm_v;

  always_comb begin
    if (cfg.wide) begin
      case (cfg.words)
        2'd1:    asm_v = {{(ASM_W-BUS_W){1'b0}}, din};
        2'd2:    asm_v = {{(ASM_W-2*BUS_W){1'b0}}, din, w0};
        default: asm_v = {din, w1, w0};
      endcase
    end else begin
      case (cfg.words)
        2'd1:    asm_v = {{(ASM_W-BYTE_W){1'b0}}, din[7:0]};
        2'd2:    asm_v = {{(ASM_W-2*BYTE_W){1'b0}}, din[7:0], w0[7:0]};
        default: asm_v = {{(ASM_W-3*BYTE_W){1'b0}}, din[7:0], w1[7:0], w0[7:0]};
      endcase
    end
  end

  always_comb begin
    lane0  = '0;
    lane1  = '0;
    mask   = '0;
    direct = 1'b0;
    case (cfg.fmt)
      FMT_IDX1: begin
        lane0 = {16'h0000, asm_v[7:0]};
        mask  = 2'b01;
      end
      FMT_IDX2: begin
        lane0 = {16'h0000, asm_v[7:0]};
        lane1 = {16'h0000, asm_v[15:8]};
        mask  = 2'b11;
      end
      FMT_555: begin
        lane0 = from555(asm_v[14:0]);  mask = 2'b01; direct = 1'b1;
      end
      FMT_565: begin
        lane0 = from565(asm_v[15:0]);  mask = 2'b01; direct = 1'b1;
      end
      FMT_888: begin
        lane0 = asm_v[23:0];           mask = 2'b01; direct = 1'b1;
      end
      FMT_PACK: begin
        lane0 = asm_v[23:0];
        lane1 = asm_v[47:24];
        mask  = 2'b11;
        direct = 1'b1;
      end
      default: begin
        mask = 2'b00;
      end
    endcase
  end
endmodule

// File: rtl/pxa_checksum.sv
module pxa_checksum
  import pxa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [LANES-1:0] step,
  input  logic [RGB_W-1:0] p0,
  input  logic [RGB_W-1:0] p1,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] nxt;
  logic [RGB_W-1:0] lane_px [LANES];

  always_comb begin
    lane_px[0] = p0;
    lane_px[1] = p1;
    nxt = sum;
    for (int k = 0; k < LANES; k++) begin
      if (step[k]) nxt = sum_step(nxt, lane_px[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sum <= '0;
    else if (clear) sum <= '0;
    else            sum <= nxt;
  end
endmodule

// File: rtl/pix_port_assembler.sv
module pix_port_assembler
  import pxa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_rdata,
  input  logic             blank_in,
  input  logic [BUS_W-1:0] pix_in,
  output logic [LANES-1:0] pix_valid,
  output logic             pix_direct,
  output logic [RGB_W-1:0] pix0,
  output logic [RGB_W-1:0] pix1,
  output logic             blank_out,
  output logic             pdown_out,
  output logic             synth_off,
  output logic [SUM_W-1:0] checksum
);
  mode_cfg_t        cfg;
  logic             pdown;
  logic             test_on;
  logic             test_arm;
  logic             active;
  logic             restart;
  logic             emit;
  logic [BUS_W-1:0] w0;
  logic [BUS_W-1:0] w1;
  logic [RGB_W-1:0] lane0;
  logic [RGB_W-1:0] lane1;
  logic [LANES-1:0] mask;
  logic             direct;
  logic [LANES-1:0] sum_step_en;

  pxa_cmd_reg u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cmd_we),
    .wdata     (cmd_wdata),
    .rdata     (cmd_rdata),
    .cfg       (cfg),
    .pdown     (pdown),
    .test_on   (test_on),
    .synth_off (synth_off),
    .test_arm  (test_arm)
  );

  always_comb begin
    active  = !pdown && (cfg.fmt != FMT_RSV);
    restart = blank_in || cmd_we || !active;
  end

  pxa_gather u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .words   (cfg.words),
    .din     (pix_in),
    .w0      (w0),
    .w1      (w1),
    .last    (emit)
  );

  pxa_format u_format (
    .cfg    (cfg),
    .w0     (w0),
    .w1     (w1),
    .din    (pix_in),
    .lane0  (lane0),
    .lane1  (lane1),
    .mask   (mask),
    .direct (direct)
  );

  always_comb sum_step_en = (emit && test_on) ? mask : '0;

  pxa_checksum u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (test_arm),
    .step  (sum_step_en),
    .p0    (lane0),
    .p1    (lane1),
    .sum   (checksum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid  <= '0;
      pix_direct <= 1'b0;
      pix0       <= '0;
      pix1       <= '0;
      blank_out  <= 1'b1;
    end else begin
      blank_out <= blank_in || !active;
      if (emit) begin
        pix_valid  <= mask;
        pix_direct <= direct;
        pix0       <= lane0;
        pix1       <= lane1;
      end else begin
        pix_valid  <= '0;
        pix_direct <= 1'b0;
        pix0       <= '0;
        pix1       <= '0;
      end
    end
  end

  always_comb pdown_out = pdown;
endmodule

// File: rtl/pxa_checker.sv
module pxa_checker
  import pxa_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [CMD_W-1:0] cmd_rdata,
  input logic             blank_in,
  input logic [LANES-1:0] pix_valid,
  input logic             pix_direct,
  input logic [RGB_W-1:0] pix0,
  input logic             blank_out,
  input logic             pdown_out,
  input logic [SUM_W-1:0] checksum,
  input logic             emit,
  input logic             restart
);
  logic rsv_mode;
  always_comb rsv_mode = cmd_rdata[4] && (cmd_rdata[7:5] >= 3'd5);

  a_r1_reserved_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[3:2] == 2'b00);

  a_r2_index_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid[0] && !pix_direct) |-> (pix0[23:8] == 16'h0000));

  a_r6_second_lane_modes: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid[1] |-> (pix_valid[0] &&
      (($past({cmd_rdata[4], cmd_rdata[7:5]}) == 4'd8) ||
       ($past({cmd_rdata[4], cmd_rdata[7:5]}) == 4'd12))));

  a_r10_blank_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    blank_in |=> (pix_valid == 2'b00) && blank_out);

  a_r10_restart_no_emit: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !emit);

  a_r10_valid_not_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid != 2'b00) |-> !blank_out);

  a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_mode && !cmd_we) |=> (pix_valid == 2'b00) && blank_out && $stable(checksum));

  a_r12_pdown_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_out |=> blank_out && (pix_valid == 2'b00));

  a_r14_sum_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rdata[1] && !cmd_we) |=> $stable(checksum));
endmodule

bind pix_port_assembler pxa_checker u_chk (.*);

// File: tb/pix_port_assembler_tb.sv
`timescale 1ns/1ps
module pix_port_assembler_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [7:0]  cmd_wdata;
  logic [7:0]  cmd_rdata;
  logic        blank_in;
  logic [15:0] pix_in;
  logic [1:0]  pix_valid;
  logic        pix_direct;
  logic [23:0] pix0;
  logic [23:0] pix1;
  logic        blank_out;
  logic        pdown_out;
  logic        synth_off;
  logic [15:0] checksum;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pix_port_assembler u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .blank_in(blank_in), .pix_in(pix_in),
    .pix_valid(pix_valid), .pix_direct(pix_direct), .pix0(pix0), .pix1(pix1),
    .blank_out(blank_out), .pdown_out(pdown_out), .synth_off(synth_off),
    .checksum(checksum)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] x5(input logic [4:0] c);
    return 8'((c * 8) + (c / 4));
  endfunction
  function automatic logic [7:0] x6(input logic [5:0] c);
    return 8'((c * 4) + (c / 16));
  endfunction
  function automatic logic [23:0] e555(input logic [15:0] v);
    return {x5(v[14:10]), x5(v[9:5]), x5(v[4:0])};
  endfunction
  function automatic logic [23:0] e565(input logic [15:0] v);
    return {x5(v[15:11]), x6(v[10:5]), x5(v[4:0])};
  endfunction
  function automatic logic [15:0] sig(input logic [15:0] s, input logic [23:0] p);
    logic [15:0] r;
    r = 16'((s * 2) + (s / 32768));
    return r ^ p[15:0] ^ {8'h00, p[23:16]};
  endfunction
  function automatic int gsize(input int m);
    case (m)
      0, 8, 9, 10:         return 1;
      1, 3, 4, 5, 6, 11:   return 2;
      2, 7, 12:            return 3;
      default:             return 0;
    endcase
  endfunction
  function automatic string tag_of(input int m);
    case (m)
      0:          return "R2";
      1, 4, 5, 6: return "R3";
      3:          return "R4";
      2, 7:       return "R5";
      8:          return "R6";
      9, 10:      return "R7";
      11:         return "R8";
      12:         return "R9";
      default:    return "R11";
    endcase
  endfunction
  function automatic logic [7:0] cmd_of(input int m, input logic [3:0] low);
    logic [3:0] mm;
    mm = 4'(m);
    return {mm[2:0], mm[3], low};
  endfunction

  // expected outputs for a completed group q0..q2 (q0 earliest)
  task automatic expect_px(input int m, input logic [15:0] q0, q1, q2,
                           output logic [1:0] v, output logic d,
                           output logic [23:0] p0, output logic [23:0] p1);
    v = 2'b01; d = 1'b1; p0 = '0; p1 = '0;
    case (m)
      0:          begin d = 1'b0; p0 = {16'h0, q0[7:0]}; end
      1, 4, 5, 6: p0 = e555({q1[7:0], q0[7:0]});
      3:          p0 = e565({q1[7:0], q0[7:0]});
      2, 7:       p0 = {q2[7:0], q1[7:0], q0[7:0]};
      8:          begin v = 2'b11; d = 1'b0; p0 = {16'h0, q0[7:0]}; p1 = {16'h0, q0[15:8]}; end
      9:          p0 = e555(q0);
      10:         p0 = e565(q0);
      11:         p0 = {q1[7:0], q0};
      12:         begin v = 2'b11; p0 = {q1[7:0], q0}; p1 = {q2, q1[15:8]}; end
      default:    begin v = 2'b00; d = 1'b0; end
    endcase
  endtask

  task automatic wr_cmd(input logic [7:0] v);
    cmd_we = 1'b1; cmd_wdata = v; blank_in = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic put_word(input logic [15:0] w, input logic b);
    pix_in = w; blank_in = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] hist [12];
    logic [1:0]  ev;
    logic        ed;
    logic [23:0] e0, e1;
    logic [15:0] msum;
    logic [15:0] held;

    rst_n = 1'b0; cmd_we = 1'b0; cmd_wdata = '0; blank_in = 1'b1; pix_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R1, R2)
    chk(cmd_rdata == 8'h00, "R1 reset cmd", 64'(cmd_rdata), 64'h0);
    chk(pix_valid == 2'b00 && blank_out, "R2 reset outputs", 64'({pix_valid, blank_out}), 64'h1);
    chk(checksum == 16'h0 && !pdown_out && !synth_off, "R13 reset sum",
        64'({checksum, pdown_out, synth_off}), 64'h0);

    // R1 reserved bits, R13 synth flag
    wr_cmd(8'hFF);
    chk(cmd_rdata == 8'hF3, "R1 masked readback", 64'(cmd_rdata), 64'hF3);
    wr_cmd(8'h03);
    chk(synth_off == 1'b1, "R13 synth_off set", 64'(synth_off), 64'h1);
    wr_cmd(8'h02);
    chk(synth_off == 1'b0, "R13 synth_off clear", 64'(synth_off), 64'h0);
    wr_cmd(8'h01);
    chk(synth_off == 1'b0, "R13 synth_off needs test", 64'(synth_off), 64'h0);

    // sweep over all modes
    for (int m = 0; m < 16; m++) begin
      int g;
      g = gsize(m);
      wr_cmd(cmd_of(m, 4'b0000));
      wr_cmd(cmd_of(m, 4'b0010));
      chk(checksum == 16'h0, "R14 arm clears", 64'(checksum), 64'h0);
      msum = 16'h0;
      for (int i = 0; i < 12; i++) begin
        hist[i] = 16'(i * 16'h3B29 + m * 16'h01F3 + 16'h00A5);
        put_word(hist[i], 1'b0);
        if (g == 0) begin
          chk(pix_valid == 2'b00 && blank_out && pix0 == 24'h0, tag_of(m),
              64'({pix_valid, blank_out, pix0}), 64'({2'b00, 1'b1, 24'h0}));
        end else if ((i % g) == g - 1) begin
          int b;
          b = i - (g - 1);
          expect_px(m, hist[b], (g > 1) ? hist[b + 1] : 16'h0,
                    (g > 2) ? hist[b + 2] : 16'h0, ev, ed, e0, e1);
          chk({pix_valid, pix_direct, blank_out, pix0, pix1} == {ev, ed, 1'b0, e0, e1},
              tag_of(m), 64'({pix_valid, pix_direct, pix0, pix1}),
              64'({ev, ed, e0, e1}));
          if (ev[0]) msum = sig(msum, e0);
          if (ev[1]) msum = sig(msum, e1);
        end else begin
          chk(pix_valid == 2'b00 && !blank_out, "R10 partial group",
              64'({pix_valid, blank_out}), 64'h0);
        end
      end
      chk(checksum == msum, (g == 0) ? "R11 sum held" : "R13 signature",
          64'(checksum), 64'(msum));
    end

    // R10: blank in the middle of a 3-byte pixel
    wr_cmd(cmd_of(2, 4'b0000));
    put_word(16'h0011, 1'b0);
    put_word(16'h0022, 1'b0);
    chk(pix_valid == 2'b00, "R10 no early pixel", 64'(pix_valid), 64'h0);
    put_word(16'h0033, 1'b1);
    chk(pix_valid == 2'b00 && blank_out, "R10 blank drops", 64'({pix_valid, blank_out}), 64'h1);
    put_word(16'h0044, 1'b0);
    put_word(16'h0055, 1'b0);
    chk(pix_valid == 2'b00, "R10 restart count", 64'(pix_valid), 64'h0);
    put_word(16'h0066, 1'b0);
    chk(pix_valid == 2'b01 && pix0 == 24'h665544, "R10 realigned pixel",
        64'({pix_valid, pix0}), 64'({2'b01, 24'h665544}));

    // R12: power-down in mode 9
    wr_cmd(cmd_of(9, 4'b0001));
    chk(cmd_rdata == 8'h31 && pdown_out, "R12 pdown register", 64'({cmd_rdata, pdown_out}), 64'h63);
    for (int i = 0; i < 3; i++) begin
      put_word(16'h7C1F + 16'(i), 1'b0);
      chk(pix_valid == 2'b00 && blank_out && pix0 == 24'h0, "R12 pdown blank",
          64'({pix_valid, blank_out, pix0}), 64'({2'b00, 1'b1, 24'h0}));
    end
    wr_cmd(cmd_of(9, 4'b0000));
    chk(cmd_rdata == 8'h30 && !pdown_out, "R12 register kept", 64'(cmd_rdata), 64'h30);
    put_word(16'h4321, 1'b0);
    chk(pix_valid == 2'b01 && pix0 == e555(16'h4321), "R12 resume",
        64'(pix0), 64'(e555(16'h4321)));

    // R14: signature frozen while test off, cleared on arming
    wr_cmd(cmd_of(0, 4'b0010));
    put_word(16'h0012, 1'b0);
    put_word(16'h0034, 1'b0);
    held = sig(sig(16'h0, 24'h12), 24'h34);
    chk(checksum == held, "R13 mode0 signature", 64'(checksum), 64'(held));
    wr_cmd(cmd_of(0, 4'b0000));
    for (int i = 0; i < 4; i++) put_word(16'(16'h0090 + i), 1'b0);
    chk(pix_valid == 2'b01 && checksum == held, "R14 frozen",
        64'(checksum), 64'(held));
    wr_cmd(cmd_of(0, 4'b0010));
    chk(checksum == 16'h0, "R14 rearm clears", 64'(checksum), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule